// File: doc/BRIEF.md
# Host-Side DMA Staging Buffer with Bus Hold-Off

This block is a shallow word FIFO placed between an external host bus and an internal DMA engine. A direction setting picks the flow: either the host writes words into the buffer and the DMA engine drains them, or the DMA engine fills the buffer and the host reads the words out. Address generation and channel mode decoding live elsewhere; this block only stores words, keeps the occupancy flags and decides, every cycle, whether a host access can complete.

When a host access cannot be served, because a write finds the buffer full or a read finds it empty, the host bus cycle is stretched. The block drops its ready line for asynchronous accesses or its acknowledge line for synchronous ones, in the same cycle, and the host holds the access until the DMA side has freed a slot or supplied a word. A configuration bit turns this stretching off. The access then completes at once: a write to a full buffer is thrown away, a read from an empty buffer repeats the last word read, and a sticky error flag records the event. A flush input empties the buffer and clears that flag.

Top module: `hdb_host_buffer`

## Requirements
- R1: After reset the buffer is empty (`fifo_empty`=1, `fifo_full`=0), `err_flag`=0, `host_rdy`=1, `host_ack`=1 and `host_rdata`=0.
- R2: With `cfg_dir`=0, a host write (`host_sel`=1, `host_wr`=1) that is not held off stores `host_wdata`; while `fifo_empty`=0, `dma_rdata` shows the oldest stored word and a `dma_req` pulse removes it, so words leave in arrival order.
- R3: With `cfg_dir`=0 and `cfg_hang_dis`=0, a host write seen while `fifo_full`=1 is held off and stores nothing; the held write completes in the cycle after the DMA side removes a word, because the flags are registered.
- R4: With `cfg_dir`=1, a `dma_req` pulse stores `dma_wdata`, and a host read (`host_sel`=1, `host_wr`=0) that is not held off returns the oldest word on `host_rdata` in the same cycle and removes it.
- R5: With `cfg_dir`=1 and `cfg_hang_dis`=0, a host read seen while `fifo_empty`=1 is held off and removes nothing.
- R6: A held-off access drives `host_rdy` low when `host_sync`=0 and `host_ack` low when `host_sync`=1, in the cycle the access is presented; the other line stays high, and both are high when nothing is held off.
- R7: With `cfg_hang_dis`=1, a host write to a full buffer completes without hold-off, leaves the stored words unchanged and sets `err_flag`.
- R8: With `cfg_hang_dis`=1, a host read from an empty buffer completes without hold-off, returns the last word a host read removed (0 if none) and sets `err_flag`.
- R9: `err_flag` stays set until a flush.
- R10: A `flush` cycle empties the buffer and clears `err_flag` at the next edge; any host access presented in that cycle is held off, and no word is stored or removed in that cycle.
- R11: Accesses that do not match the direction have no effect: a host write with `cfg_dir`=1, a host read with `cfg_dir`=0 (which returns the last word read), `dma_req` on an empty buffer with `cfg_dir`=0 and `dma_req` on a full buffer with `cfg_dir`=1; none of them holds off the host.
- R12: `fifo_full` is 1 exactly when `DEPTH` (default 6) words are stored and `fifo_empty` is 1 exactly when none are; both are updated at the clock edge that changes the occupancy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir | input | 1 | 0: host fills, DMA drains; 1: DMA fills, host drains |
| cfg_hang_dis | input | 1 | 1 disables hold-off (discard / repeat plus error) |
| flush | input | 1 | Empties the buffer and clears the error flag |
| host_sel | input | 1 | Host access presented this cycle |
| host_wr | input | 1 | 1 write, 0 read |
| host_sync | input | 1 | 1 synchronous access (acknowledge line), 0 asynchronous (ready line) |
| host_wdata | input | WIDTH | Host write data |
| host_rdata | output | WIDTH | Host read data |
| host_rdy | output | 1 | Ready line, low while an asynchronous access is held off |
| host_ack | output | 1 | Acknowledge line, low while a synchronous access is held off |
| dma_req | input | 1 | DMA transfer strobe (store or remove per direction) |
| dma_wdata | input | WIDTH | DMA write data |
| dma_rdata | output | WIDTH | Oldest stored word for the DMA side |
| fifo_full | output | 1 | Registered full flag |
| fifo_empty | output | 1 | Registered empty flag |
| err_flag | output | 1 | Sticky discard/repeat error flag |

## Verification
The bench aims at the edges of occupancy: a write held against a full buffer while the DMA side removes a word in the same cycle, which a design using unregistered flags would let through one cycle early, and a read against an empty buffer, where a wrong design would hand out a stale or undefined word instead of stalling. With hold-off disabled it checks that the discarded write does not overwrite the oldest word and that an empty read repeats exactly the last word removed, which a design reusing the head slot would get wrong. It also covers the choice between ready and acknowledge lines, flushes that arrive during an access, and direction-mismatched strobes that a careless design would turn into pushes or pops.

// File: rtl/hdb_pkg.sv
package hdb_pkg;

    localparam int unsigned HDB_DEPTH_DEF = 6;
    localparam int unsigned HDB_WIDTH_DEF = 32;

    typedef enum logic {
        DIR_HOST_TO_DMA = 1'b0,
        DIR_DMA_TO_HOST = 1'b1
    } hdb_dir_e;

endpackage

// File: rtl/hdb_store.sv
module hdb_store #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    input  logic             cap_en,
    output logic [WIDTH-1:0] head,
    output logic [WIDTH-1:0] last_q
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] last_d;

    assign head = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        last_d = last_q;
        if (cap_en) begin
            last_d = head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= last_d;
        end
    end

endmodule

// File: rtl/hdb_ctrl.sv
module hdb_ctrl
    import hdb_pkg::*;
#(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hdb_dir_e      dir,
    input  logic          hang_dis,
    input  logic          flush,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_sync,
    input  logic          dma_req,
    output logic          host_rdy,
    output logic          host_ack,
    output logic          push_en,
    output logic          host_pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          full,
    output logic          empty,
    output logic          err
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          full;
        logic          empty;
        logic          err;
    } state_t;

    state_t s_d, s_q;

    logic host_wr_req, host_rd_req, starved, blocked, pop_en;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d = s_q;

        host_wr_req = host_sel &&  host_wr && (dir == DIR_HOST_TO_DMA);
        host_rd_req = host_sel && !host_wr && (dir == DIR_DMA_TO_HOST);
        starved     = (host_wr_req && s_q.full) || (host_rd_req && s_q.empty);
        blocked     = host_sel && (flush || (!hang_dis && starved));

        host_rdy = !(blocked && !host_sync);
        host_ack = !(blocked &&  host_sync);

        push_en = !flush && !s_q.full &&
                  ((dir == DIR_HOST_TO_DMA) ? host_wr_req : dma_req);
        pop_en  = !flush && !s_q.empty &&
                  ((dir == DIR_HOST_TO_DMA) ? dma_req : host_rd_req);
        host_pop = pop_en && (dir == DIR_DMA_TO_HOST);

        if (push_en) begin
            s_d.wr_ptr = wrap_inc(s_q.wr_ptr);
        end
        if (pop_en) begin
            s_d.rd_ptr = wrap_inc(s_q.rd_ptr);
        end
        if (push_en && !pop_en) begin
            s_d.count = s_q.count + CW'(1);
        end else if (pop_en && !push_en) begin
            s_d.count = s_q.count - CW'(1);
        end

        if (hang_dis && starved) begin
            s_d.err = 1'b1;
        end

        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.count  = '0;
            s_d.err    = 1'b0;
        end

        s_d.full  = (s_d.count == CW'(DEPTH));
        s_d.empty = (s_d.count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr_ptr: '0, rd_ptr: '0, count: '0,
                     full: 1'b0, empty: 1'b1, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_ptr = s_q.wr_ptr;
    assign rd_ptr = s_q.rd_ptr;
    assign full   = s_q.full;
    assign empty  = s_q.empty;
    assign err    = s_q.err;

endmodule

// File: rtl/hdb_host_buffer.sv
module hdb_host_buffer
    import hdb_pkg::*;
#(
    parameter int unsigned DEPTH = HDB_DEPTH_DEF,
    parameter int unsigned WIDTH = HDB_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dir,
    input  logic             cfg_hang_dis,
    input  logic             flush,
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic             host_sync,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    output logic             host_rdy,
    output logic             host_ack,
    input  logic             dma_req,
    input  logic [WIDTH-1:0] dma_wdata,
    output logic [WIDTH-1:0] dma_rdata,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             err_flag
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    hdb_dir_e         dir;
    logic             push_en, host_pop;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [WIDTH-1:0] wdata_mux, head, last_word;

    assign dir       = hdb_dir_e'(cfg_dir);
    assign wdata_mux = (dir == DIR_HOST_TO_DMA) ? host_wdata : dma_wdata;

    hdb_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir       (dir),
        .hang_dis  (cfg_hang_dis),
        .flush     (flush),
        .host_sel  (host_sel),
        .host_wr   (host_wr),
        .host_sync (host_sync),
        .dma_req   (dma_req),
        .host_rdy  (host_rdy),
        .host_ack  (host_ack),
        .push_en   (push_en),
        .host_pop  (host_pop),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .err       (err_flag)
    );

    hdb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (push_en),
        .waddr  (wr_ptr),
        .wdata  (wdata_mux),
        .raddr  (rd_ptr),
        .cap_en (host_pop),
        .head   (head),
        .last_q (last_word)
    );

    assign host_rdata = host_pop ? head : last_word;
    assign dma_rdata  = head;

endmodule

// File: rtl/hdb_host_buffer_chk.sv
module hdb_host_buffer_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_dir,
    input logic cfg_hang_dis,
    input logic flush,
    input logic host_sel,
    input logic host_wr,
    input logic host_sync,
    input logic host_rdy,
    input logic host_ack,
    input logic fifo_full,
    input logic fifo_empty,
    input logic err_flag
);

    p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_full_write_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_wr && !cfg_dir && fifo_full && !cfg_hang_dis && !flush)
        |-> !(host_rdy && host_ack));

    p_empty_read_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && cfg_dir && fifo_empty && !cfg_hang_dis && !flush)
        |-> !(host_rdy && host_ack));

    p_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy || host_ack);

    p_line_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_sync) |-> host_rdy);

    p_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hang_dis && !flush) |-> (host_rdy && host_ack));

    p_empty_read_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && cfg_dir && fifo_empty && cfg_hang_dis && !flush)
        |=> err_flag);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !flush) |=> err_flag);

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_empty && !err_flag));

endmodule

bind hdb_host_buffer hdb_host_buffer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dir      (cfg_dir),
    .cfg_hang_dis (cfg_hang_dis),
    .flush        (flush),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_sync    (host_sync),
    .host_rdy     (host_rdy),
    .host_ack     (host_ack),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .err_flag     (err_flag)
);

// File: tb/hdb_host_buffer_tb.sv
`timescale 1ns/1ps
module hdb_host_buffer_tb;

    localparam int DEPTH = 6;
    localparam int WIDTH = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_dir = 1'b0, cfg_hang_dis = 1'b0, flush = 1'b0;
    logic             host_sel = 1'b0, host_wr = 1'b0, host_sync = 1'b0;
    logic [WIDTH-1:0] host_wdata = '0, dma_wdata = '0;
    logic             dma_req = 1'b0;
    logic [WIDTH-1:0] host_rdata, dma_rdata;
    logic             host_rdy, host_ack, fifo_full, fifo_empty, err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [WIDTH-1:0] q[$];
    logic [WIDTH-1:0] m_last = '0;
    bit               m_err = 0;

    always #4 clk = ~clk;

    hdb_host_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_hang_dis(cfg_hang_dis),
        .flush(flush), .host_sel(host_sel), .host_wr(host_wr), .host_sync(host_sync),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
        .host_ack(host_ack), .dma_req(dma_req), .dma_wdata(dma_wdata),
        .dma_rdata(dma_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .err_flag(err_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_blocked();
        bit full = (q.size() == DEPTH);
        bit empty = (q.size() == 0);
        bit starve = (host_sel && host_wr && !cfg_dir && full) ||
                     (host_sel && !host_wr && cfg_dir && empty);
        return host_sel && (flush || (!cfg_hang_dis && starve));
    endfunction

    // One clock: compare outputs against the model, then advance the model.
    task automatic cyc(input string tag);
        bit full, empty, blk, push, pop, wreq, rreq, starve;
        #1;
        full  = (q.size() == DEPTH);
        empty = (q.size() == 0);
        wreq  = host_sel && host_wr && !cfg_dir;
        rreq  = host_sel && !host_wr && cfg_dir;
        starve = (wreq && full) || (rreq && empty);
        blk   = exp_blocked();
        push  = !flush && !full && (cfg_dir ? dma_req : wreq);
        pop   = !flush && !empty && (cfg_dir ? rreq : dma_req);
        chk("R12", "fifo_full", WIDTH'(fifo_full), WIDTH'(full));
        chk("R12", "fifo_empty", WIDTH'(fifo_empty), WIDTH'(empty));
        chk("R9", "err_flag", WIDTH'(err_flag), WIDTH'(m_err));
        chk(tag, "host_rdy", WIDTH'(host_rdy), WIDTH'(!(blk && !host_sync)));
        chk(tag, "host_ack", WIDTH'(host_ack), WIDTH'(!(blk && host_sync)));
        chk(tag, "host_rdata", host_rdata, (pop && cfg_dir) ? q[0] : m_last);
        if (!empty) chk(tag, "dma_rdata", dma_rdata, q[0]);
        @(posedge clk);
        if (flush) begin
            q.delete();
            m_err = 0;
        end else begin
            if (cfg_hang_dis && starve) m_err = 1;
            if (pop) begin
                if (cfg_dir) m_last = q[0];
                void'(q.pop_front());
            end
            if (push) q.push_back(cfg_dir ? dma_wdata : host_wdata);
        end
        @(negedge clk);
    endtask

    task automatic op(input bit sel, input bit wr, input bit sync,
                      input logic [WIDTH-1:0] hd, input bit dreq,
                      input logic [WIDTH-1:0] dd, input bit fl, input string tag);
        host_sel = sel; host_wr = wr; host_sync = sync; host_wdata = hd;
        dma_req = dreq; dma_wdata = dd; flush = fl;
        cyc(tag);
        host_sel = 0; dma_req = 0; flush = 0;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc("R1");

        // R2 / R3 / R6: host fills, hold-off on full
        cfg_dir = 0; cfg_hang_dis = 0;
        for (int i = 0; i < DEPTH; i++) op(1, 1, 0, 32'hA000_0000 + i, 0, '0, 0, "R2");
        op(1, 1, 0, 32'hBEEF_0001, 0, '0, 0, "R3");
        op(1, 1, 1, 32'hBEEF_0001, 0, '0, 0, "R6");
        op(1, 1, 0, 32'hBEEF_0001, 1, '0, 0, "R3");   // pop same cycle: still held
        op(1, 1, 0, 32'hBEEF_0001, 0, '0, 0, "R3");   // now completes
        for (int i = 0; i < DEPTH + 1; i++) op(0, 0, 0, '0, 1, '0, 0, "R2");
        op(0, 0, 0, '0, 1, '0, 0, "R11");             // dma pop on empty
        op(1, 0, 0, '0, 0, '0, 0, "R11");             // host read in wrong direction

        // R4 / R5: DMA fills, host drains
        cfg_dir = 1;
        for (int i = 0; i < DEPTH + 1; i++) op(0, 0, 0, '0, 1, 32'hC000_0000 + i, 0, "R4");
        op(0, 0, 0, '0, 1, 32'hDEAD_0000, 0, "R11");  // dma push on full
        op(1, 1, 0, 32'h1111_1111, 0, '0, 0, "R11");  // host write in wrong direction
        for (int i = 0; i < DEPTH; i++) op(1, 0, i[0], '0, 0, '0, 0, "R4");
        op(1, 0, 0, '0, 0, '0, 0, "R5");
        op(1, 0, 1, '0, 0, '0, 0, "R5");
        op(1, 0, 0, '0, 1, 32'hC0DE_0001, 0, "R5");   // supplied same cycle: still held
        op(1, 0, 0, '0, 0, '0, 0, "R4");

        // R8: no hold-off, read from empty repeats last word
        cfg_hang_dis = 1;
        op(1, 0, 0, '0, 0, '0, 0, "R8");
        op(1, 0, 1, '0, 0, '0, 0, "R8");
        op(0, 0, 0, '0, 0, '0, 0, "R9");

        // R10: flush with a host access present
        op(1, 1, 1, '0, 1, 32'h5555_5555, 1, "R10");
        op(0, 0, 0, '0, 0, '0, 0, "R10");

        // R7: no hold-off, write to full is discarded
        cfg_dir = 0;
        for (int i = 0; i < DEPTH; i++) op(1, 1, 0, 32'hE000_0000 + i, 0, '0, 0, "R7");
        op(1, 1, 0, 32'hFFFF_FFFF, 0, '0, 0, "R7");
        op(1, 1, 1, 32'hFFFF_FFFE, 0, '0, 0, "R7");
        for (int i = 0; i < DEPTH; i++) op(0, 0, 0, '0, 1, '0, 0, "R7");
        op(0, 0, 0, '0, 0, '0, 1, "R10");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                cfg_dir = $urandom_range(1);
                cfg_hang_dis = ($urandom_range(3) == 0);
            end
            op($urandom_range(9) < 6,
               ($urandom_range(9) == 0) ? cfg_dir : !cfg_dir,
               $urandom_range(1), $urandom, $urandom_range(1), $urandom,
               $urandom_range(99) == 0, cfg_dir ? "R4" : "R2");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule